// File: doc/BRIEF.md
# Dual-Width General Register File

This block is the integer register file of a 64-bit load/store core. It keeps thirty-one 64-bit general registers, addressed 0 to 30, plus a separate stack pointer. Two read ports and one write port share a 5-bit index space. Index 30 doubles as the link register, and a dedicated link write path fills it when a call retires. Index 31 has no storage of its own. Each port has a mode input that turns index 31 into either a constant-zero source or sink, or an access to the stack pointer.

Every port has a width select. A narrow read shows the low word with the high word forced to zero. A narrow write stores the low word and clears the high word. On the wide write path, a sign-extend control widens a loaded 32-bit word by copying its bit 31 across the upper half. Reads are combinational. Writes take effect on the rising clock edge.

Top module: `gpr_file`

## Requirements
- R1: A 64-bit write (`wr_w64_i`=1, `wr_sext_i`=0) to index 0..30 is visible in full on either read port from the cycle after the write edge.
- R2: Reads are combinational from the stored state: reading an index in the same cycle it is written returns the previous contents.
- R3: With the port's stack mode low, index 31 reads as all zeros. A write to index 31 with `wr_sp_i`=0 is discarded, and the stack pointer keeps its value.
- R4: With the port's stack mode high, index 31 reads and writes a 64-bit stack pointer that is distinct from every general register.
- R5: A read with width select 0 returns bits 31:0 of the selected register, with bits 63:32 of the output at zero.
- R6: A write with `wr_w64_i`=0 stores bits 31:0 of `wr_data_i` and clears bits 63:32. `wr_sext_i` has no effect in this case.
- R7: A write with `wr_w64_i`=1 and `wr_sext_i`=1 stores bits 31:0 of `wr_data_i` and fills bits 63:32 with copies of bit 31.
- R8: `link_en_i` writes the full `link_addr_i` into index 30 on the clock edge. If the write port targets index 30 in the same cycle, the link write wins. A port write to any other index in that cycle still lands.
- R9: While `rst_ni` is low, all general registers and the stack pointer are cleared to zero.
- R10: The two read ports select index, stack mode and width independently, so the same index can be seen in different views on the two ports in one cycle.
- R11: With `wr_en_i` low, the write port changes no register and does not change the stack pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd_a_idx_i | input | 5 | Read port A index |
| rd_a_sp_i | input | 1 | Port A: index 31 selects the stack pointer (1) or zero (0) |
| rd_a_w64_i | input | 1 | Port A: 64-bit view (1) or 32-bit view (0) |
| rd_a_data_o | output | 64 | Port A read data |
| rd_b_idx_i | input | 5 | Read port B index |
| rd_b_sp_i | input | 1 | Port B: index 31 selects the stack pointer (1) or zero (0) |
| rd_b_w64_i | input | 1 | Port B: 64-bit view (1) or 32-bit view (0) |
| rd_b_data_o | output | 64 | Port B read data |
| wr_en_i | input | 1 | Write port enable |
| wr_idx_i | input | 5 | Write port index |
| wr_sp_i | input | 1 | Write: index 31 selects the stack pointer (1) or discard (0) |
| wr_w64_i | input | 1 | Write: 64-bit (1) or 32-bit zero-cleared (0) |
| wr_sext_i | input | 1 | Write: sign-widen bit 31 (only when `wr_w64_i`=1) |
| wr_data_i | input | 64 | Write data |
| link_en_i | input | 1 | Write `link_addr_i` into index 30 |
| link_addr_i | input | 64 | Return address for the link register |

## Verification
The bench builds the block with its default parameters: a 64-bit word and 32 encodings. This places the zero/stack encoding at 31 and the link register at 30, so every special index sits at its real position. A 64-bit word puts the high word, bits 63:32, apart from the low word. Narrow views, upper-half clearing and the bit-31 sign fill can then each be seen on their own. The vector table runs each write format followed by a read in the selected view. Directed tests cover the reset state, reading an index in the same cycle it is written, a link write colliding with a port write, and the two ports seeing index 31 in different modes at once.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  // internal write formats produced by the widening stage
  typedef enum logic [1:0] {
    WR_FULL = 2'd0,
    WR_ZEXT = 2'd1,
    WR_SEXT = 2'd2
  } wr_fmt_e;

  function automatic wr_fmt_e decode_fmt(input logic w64, input logic sext);
    if (!w64)     return WR_ZEXT;
    else if (sext) return WR_SEXT;
    else          return WR_FULL;
  endfunction
endpackage

// File: rtl/gpr_extend.sv
module gpr_extend
  import gpr_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              w64_i,
  input  logic              sext_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int HALF_W = DATA_W / 2;

  wr_fmt_e fmt;
  logic [HALF_W-1:0] lo;

  assign fmt = decode_fmt(w64_i, sext_i);
  assign lo  = data_i[HALF_W-1:0];

  always_comb begin
    unique case (fmt)
      WR_ZEXT: data_o = {{HALF_W{1'b0}}, lo};
      WR_SEXT: data_o = {{HALF_W{lo[HALF_W-1]}}, lo};
      default: data_o = data_i;
    endcase
  end
endmodule

// File: rtl/gpr_wr_decode.sv
module gpr_wr_decode #(
  parameter int NUM_REGS = 32,
  parameter int ADDR_W   = $clog2(NUM_REGS)
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_idx_i,
  input  logic              wr_sp_i,
  input  logic              link_en_i,
  output logic [NUM_REGS-2:0] gpr_we_o,
  output logic              sp_we_o
);
  localparam int NUM_GPR = NUM_REGS - 1;
  localparam int LR_IDX  = NUM_REGS - 2;
  localparam logic [ADDR_W-1:0] SPECIAL = ADDR_W'(NUM_REGS - 1);

  for (genvar g = 0; g < NUM_GPR; g++) begin : g_we
    if (g == LR_IDX) begin : g_lr
      // link write has priority over the port
      assign gpr_we_o[g] = wr_en_i && (wr_idx_i == ADDR_W'(g)) && !link_en_i;
    end else begin : g_plain
      assign gpr_we_o[g] = wr_en_i && (wr_idx_i == ADDR_W'(g));
    end
  end

  assign sp_we_o = wr_en_i && (wr_idx_i == SPECIAL) && wr_sp_i;
endmodule

// File: rtl/gpr_read_port.sv
module gpr_read_port #(
  parameter int DATA_W   = 64,
  parameter int NUM_REGS = 32,
  parameter int ADDR_W   = $clog2(NUM_REGS)
) (
  input  logic [DATA_W-1:0] regs_i [NUM_REGS-1],
  input  logic [DATA_W-1:0] sp_i,
  input  logic [ADDR_W-1:0] idx_i,
  input  logic              sp_mode_i,
  input  logic              w64_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int HALF_W = DATA_W / 2;
  localparam logic [ADDR_W-1:0] SPECIAL = ADDR_W'(NUM_REGS - 1);

  logic [DATA_W-1:0] raw;

  always_comb begin
    if (idx_i == SPECIAL) raw = sp_mode_i ? sp_i : '0;
    else                  raw = regs_i[idx_i];
  end

  assign data_o = w64_i ? raw : {{HALF_W{1'b0}}, raw[HALF_W-1:0]};
endmodule

// File: rtl/gpr_file.sv
module gpr_file #(
  parameter int DATA_W   = 64,
  parameter int NUM_REGS = 32,
  parameter int ADDR_W   = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] rd_a_idx_i,
  input  logic              rd_a_sp_i,
  input  logic              rd_a_w64_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  input  logic [ADDR_W-1:0] rd_b_idx_i,
  input  logic              rd_b_sp_i,
  input  logic              rd_b_w64_i,
  output logic [DATA_W-1:0] rd_b_data_o,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_idx_i,
  input  logic              wr_sp_i,
  input  logic              wr_w64_i,
  input  logic              wr_sext_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              link_en_i,
  input  logic [DATA_W-1:0] link_addr_i
);
  localparam int NUM_GPR = NUM_REGS - 1;
  localparam int LR_IDX  = NUM_REGS - 2;

  logic [DATA_W-1:0]  regs_q [NUM_GPR];
  logic [DATA_W-1:0]  sp_q;
  logic [DATA_W-1:0]  wr_word;
  logic [NUM_GPR-1:0] gpr_we;
  logic               sp_we;

  gpr_extend #(.DATA_W(DATA_W)) u_ext (
    .data_i (wr_data_i),
    .w64_i  (wr_w64_i),
    .sext_i (wr_sext_i),
    .data_o (wr_word)
  );

  gpr_wr_decode #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_dec (
    .wr_en_i   (wr_en_i),
    .wr_idx_i  (wr_idx_i),
    .wr_sp_i   (wr_sp_i),
    .link_en_i (link_en_i),
    .gpr_we_o  (gpr_we),
    .sp_we_o   (sp_we)
  );

  for (genvar g = 0; g < NUM_GPR; g++) begin : g_reg
    if (g == LR_IDX) begin : g_lr
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        regs_q[g] <= '0;
        else if (link_en_i) regs_q[g] <= link_addr_i;
        else if (gpr_we[g]) regs_q[g] <= wr_word;
      end
    end else begin : g_plain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        regs_q[g] <= '0;
        else if (gpr_we[g]) regs_q[g] <= wr_word;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sp_q <= '0;
    else if (sp_we) sp_q <= wr_word;
  end

  gpr_read_port #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_rd_a (
    .regs_i    (regs_q),
    .sp_i      (sp_q),
    .idx_i     (rd_a_idx_i),
    .sp_mode_i (rd_a_sp_i),
    .w64_i     (rd_a_w64_i),
    .data_o    (rd_a_data_o)
  );

  gpr_read_port #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_rd_b (
    .regs_i    (regs_q),
    .sp_i      (sp_q),
    .idx_i     (rd_b_idx_i),
    .sp_mode_i (rd_b_sp_i),
    .w64_i     (rd_b_w64_i),
    .data_o    (rd_b_data_o)
  );
endmodule

// File: rtl/gpr_file_chk.sv
module gpr_file_chk #(
  parameter int DATA_W   = 64,
  parameter int NUM_REGS = 32,
  parameter int ADDR_W   = $clog2(NUM_REGS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] rd_a_idx_i,
  input logic              rd_a_sp_i,
  input logic              rd_a_w64_i,
  input logic [DATA_W-1:0] rd_a_data_o,
  input logic [ADDR_W-1:0] rd_b_idx_i,
  input logic              rd_b_sp_i,
  input logic              rd_b_w64_i,
  input logic [DATA_W-1:0] rd_b_data_o,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_idx_i,
  input logic              wr_sp_i,
  input logic              wr_w64_i,
  input logic              wr_sext_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              link_en_i,
  input logic [DATA_W-1:0] link_addr_i
);
  localparam int HALF_W = DATA_W / 2;
  localparam logic [ADDR_W-1:0] SPECIAL = ADDR_W'(NUM_REGS - 1);
  localparam logic [ADDR_W-1:0] LR      = ADDR_W'(NUM_REGS - 2);

  logic gpr_wr;
  assign gpr_wr = wr_en_i && wr_idx_i != SPECIAL && !(link_en_i && wr_idx_i == LR);

  assert_full_write_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gpr_wr && wr_w64_i && !wr_sext_i) |=>
      (!(rd_a_idx_i == $past(wr_idx_i) && rd_a_w64_i) || rd_a_data_o == $past(wr_data_i)));

  assert_zero_read_a_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_a_idx_i == SPECIAL && !rd_a_sp_i) |-> rd_a_data_o == '0);

  assert_zero_read_b_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_b_idx_i == SPECIAL && !rd_b_sp_i) |-> rd_b_data_o == '0);

  assert_narrow_view_a_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_a_w64_i |-> rd_a_data_o[DATA_W-1:HALF_W] == '0);

  assert_narrow_view_b_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_b_w64_i |-> rd_b_data_o[DATA_W-1:HALF_W] == '0);

  assert_narrow_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gpr_wr && !wr_w64_i) |=>
      (!(rd_b_idx_i == $past(wr_idx_i) && rd_b_w64_i) ||
       rd_b_data_o == {{HALF_W{1'b0}}, $past(wr_data_i[HALF_W-1:0])}));

  assert_sign_fill_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gpr_wr && wr_w64_i && wr_sext_i) |=>
      (!(rd_a_idx_i == $past(wr_idx_i) && rd_a_w64_i) ||
       rd_a_data_o[DATA_W-1:HALF_W] == {HALF_W{$past(wr_data_i[HALF_W-1])}}));

  assert_link_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_en_i |=> (!(rd_b_idx_i == LR && rd_b_w64_i) || rd_b_data_o == $past(link_addr_i)));
endmodule

bind gpr_file gpr_file_chk #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/gpr_file_test.sv
module gpr_file_test;
  localparam int DW = 64;
  localparam int NR = 32;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] ra_idx = '0, rb_idx = '0, w_idx = '0;
  logic ra_sp = 1'b0, ra_w64 = 1'b1, rb_sp = 1'b0, rb_w64 = 1'b1;
  logic w_en = 1'b0, w_sp = 1'b0, w_w64 = 1'b1, w_sext = 1'b0, l_en = 1'b0;
  logic [DW-1:0] w_data = '0, l_addr = '0;
  logic [DW-1:0] ra_data, rb_data;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  gpr_file uut (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_a_idx_i(ra_idx), .rd_a_sp_i(ra_sp), .rd_a_w64_i(ra_w64), .rd_a_data_o(ra_data),
    .rd_b_idx_i(rb_idx), .rd_b_sp_i(rb_sp), .rd_b_w64_i(rb_w64), .rd_b_data_o(rb_data),
    .wr_en_i(w_en), .wr_idx_i(w_idx), .wr_sp_i(w_sp), .wr_w64_i(w_w64), .wr_sext_i(w_sext),
    .wr_data_i(w_data), .link_en_i(l_en), .link_addr_i(l_addr)
  );

  typedef struct packed {
    logic [4:0]  widx;
    logic        wsp;
    logic        w64;
    logic        sext;
    logic [63:0] wdata;
    logic [4:0]  ridx;
    logic        rsp;
    logic        r64;
    logic [63:0] exp;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{5'd5,  1'b0, 1'b1, 1'b0, 64'h0123_4567_89AB_CDEF, 5'd5,  1'b0, 1'b1, 64'h0123_4567_89AB_CDEF}, // R1
    '{5'd5,  1'b0, 1'b0, 1'b0, 64'hFFFF_FFFF_8000_0001, 5'd5,  1'b0, 1'b1, 64'h0000_0000_8000_0001}, // R6
    '{5'd7,  1'b0, 1'b1, 1'b1, 64'h0000_0000_8000_0002, 5'd7,  1'b0, 1'b1, 64'hFFFF_FFFF_8000_0002}, // R7
    '{5'd8,  1'b0, 1'b1, 1'b1, 64'hAAAA_AAAA_7FFF_FFFF, 5'd8,  1'b0, 1'b1, 64'h0000_0000_7FFF_FFFF}, // R7
    '{5'd9,  1'b0, 1'b1, 1'b0, 64'hDEAD_BEEF_CAFE_F00D, 5'd9,  1'b0, 1'b0, 64'h0000_0000_CAFE_F00D}, // R5
    '{5'd31, 1'b1, 1'b1, 1'b0, 64'h0000_7FFF_FFFF_FFF0, 5'd31, 1'b1, 1'b1, 64'h0000_7FFF_FFFF_FFF0}, // R4
    '{5'd0,  1'b0, 1'b1, 1'b0, 64'h1111_2222_3333_4444, 5'd31, 1'b0, 1'b1, 64'h0},                   // R3
    '{5'd30, 1'b0, 1'b1, 1'b0, 64'h2222_3333_4444_5555, 5'd30, 1'b0, 1'b1, 64'h2222_3333_4444_5555}, // R1
    '{5'd31, 1'b0, 1'b1, 1'b0, 64'h5555_5555_5555_5555, 5'd31, 1'b1, 1'b1, 64'h0000_7FFF_FFFF_FFF0}, // R3
    '{5'd31, 1'b1, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 5'd31, 1'b1, 1'b1, 64'h0000_0000_FFFF_FFFF}, // R6
    '{5'd0,  1'b0, 1'b1, 1'b0, 64'h1111_2222_3333_4444, 5'd0,  1'b0, 1'b1, 64'h1111_2222_3333_4444}  // R1
  };

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] idx, input logic sp, input logic w64,
                          input logic sext, input logic [DW-1:0] d);
    @(negedge clk);
    w_en = 1'b1; w_idx = idx; w_sp = sp; w_w64 = w64; w_sext = sext; w_data = d;
    @(posedge clk);
    #1;
    w_en = 1'b0;
  endtask

  task automatic set_a(input logic [AW-1:0] idx, input logic sp, input logic w64);
    ra_idx = idx; ra_sp = sp; ra_w64 = w64;
    #1;
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog act=%h exp=%h", 64'h0, 64'h1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    w_data = 64'hFFFF_FFFF_FFFF_FFFF;
    #45;
    // R9: state is zero while and after reset
    for (int i = 0; i < NR; i++) begin
      set_a(AW'(i), 1'b1, 1'b1);
      check("R9", ra_data, '0);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // table walk
    for (int v = 0; v < NV; v++) begin
      do_write(VECS[v].widx, VECS[v].wsp, VECS[v].w64, VECS[v].sext, VECS[v].wdata);
      set_a(VECS[v].ridx, VECS[v].rsp, VECS[v].r64);
      check($sformatf("vec%0d", v), ra_data, VECS[v].exp);
    end

    // R2: read in the write cycle shows the old value
    @(negedge clk);
    w_en = 1'b1; w_idx = 5'd3; w_sp = 1'b0; w_w64 = 1'b1; w_sext = 1'b0;
    w_data = 64'h0BAD_F00D_0BAD_F00D;
    set_a(5'd3, 1'b0, 1'b1);
    check("R2 before edge", ra_data, '0);
    @(posedge clk);
    #1;
    w_en = 1'b0;
    check("R2 after edge", ra_data, 64'h0BAD_F00D_0BAD_F00D);

    // R8: link beats port write to index 30
    @(negedge clk);
    l_en = 1'b1; l_addr = 64'h0000_0000_0040_1000;
    w_en = 1'b1; w_idx = 5'd30; w_data = 64'h9999_9999_9999_9999;
    @(posedge clk);
    #1;
    l_en = 1'b0; w_en = 1'b0;
    set_a(5'd30, 1'b0, 1'b1);
    check("R8 priority", ra_data, 64'h0000_0000_0040_1000);

    // R8: link and port write to another index both land
    @(negedge clk);
    l_en = 1'b1; l_addr = 64'h0000_0000_0040_2000;
    w_en = 1'b1; w_idx = 5'd4; w_w64 = 1'b1; w_sext = 1'b0; w_data = 64'h4444_0000_4444_0000;
    @(posedge clk);
    #1;
    l_en = 1'b0; w_en = 1'b0;
    set_a(5'd30, 1'b0, 1'b1);
    check("R8 link", ra_data, 64'h0000_0000_0040_2000);
    set_a(5'd4, 1'b0, 1'b1);
    check("R8 other", ra_data, 64'h4444_0000_4444_0000);

    // R11: disabled port changes nothing
    @(negedge clk);
    w_en = 1'b0; w_idx = 5'd4; w_data = 64'h7777_7777_7777_7777;
    @(posedge clk);
    #1;
    check("R11 gpr", ra_data, 64'h4444_0000_4444_0000);
    @(negedge clk);
    w_idx = 5'd31; w_sp = 1'b1;
    @(posedge clk);
    #1;
    set_a(5'd31, 1'b1, 1'b1);
    check("R11 sp", ra_data, 64'h0000_0000_FFFF_FFFF);

    // R10: ports pick views independently
    ra_idx = 5'd31; ra_sp = 1'b0; ra_w64 = 1'b1;
    rb_idx = 5'd31; rb_sp = 1'b1; rb_w64 = 1'b1;
    #1;
    check("R10 a zero", ra_data, '0);
    check("R10 b sp", rb_data, 64'h0000_0000_FFFF_FFFF);
    ra_idx = 5'd4; ra_w64 = 1'b0;
    rb_idx = 5'd4; rb_w64 = 1'b1;
    #1;
    check("R10 a narrow", ra_data, 64'h0000_0000_4444_0000);
    check("R10 b wide", rb_data, 64'h4444_0000_4444_0000);

    // R4: stack pointer does not alias index 30 or 0
    set_a(5'd0, 1'b1, 1'b1);
    check("R4 x0 sp mode", ra_data, 64'h1111_2222_3333_4444);

    // R9: asynchronous reset clears everything
    #3;
    rst_n = 1'b0;
    #2;
    set_a(5'd4, 1'b0, 1'b1);
    check("R9 async gpr", ra_data, '0);
    set_a(5'd31, 1'b1, 1'b1);
    check("R9 async sp", ra_data, '0);
    rst_n = 1'b1;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule